// File: doc/BRIEF.md
# Graphics DRAM Extended Mode Register Controller

This block sits on the command side of a graphics DRAM device model. It watches the command strobes and bank address on every clock. When an extended mode register write appears, it checks that the device can take the write: all banks precharged, clock enable high for two cycles, and no earlier write still settling. If the checks pass, it captures the address bits into the stored register. The stored bits drive decoded configuration outputs: driver impedance, data termination, DLL enable, additive latency, write recovery time, pull-up resistance, command/address termination and a vendor ID request.

Each write that is taken starts a settling window of `TMRD` clocks. Any extended write that arrives during the window is refused. Every command that is seen produces exactly one one-cycle result pulse: accepted, rejected, or protocol error. A power-up default for the data termination comes from the clock-enable level at the moment reset is released.

Top module: `xmr_unit`

## Requirements
- R1: An extended write is decoded when `csN`, `rasN`, `casN` and `weN` are all 0 in the same cycle with `bankAddr` = 2'b01. When it is taken, `accepted` pulses high for exactly one cycle, in the cycle after the command edge. The new field values appear in that same cycle.
- R2: The stored bits [1:0] set `driveOhms`: 00 gives 0 (automatic calibration), 01 gives 30, 10 gives 40 and 11 gives 50. The stored bits [3:2] appear on `termCode`: 00 means termination off, 10 means ZQ/4 and 11 means ZQ/2. `odtOn` is 1 whenever `termCode` is not 00.
- R3: Stored bit 6 = 0 gives `dllEnable` = 1, and bit 6 = 1 gives `dllEnable` = 0. Stored bit 8 appears on `addLatency` (0 or 1 clock). Stored bit 9 sets `pullUpOhms`: 0 gives 40 and 1 gives 60.
- R4: Stored bit 11 appears on `caTermHalf`, where 1 means half of the default termination. Stored bit 10 appears on `vendorIdReq`.
- R5: The write recovery code is {bit7, bit5, bit4}. It sets `wrRecovery` as follows: codes 0 to 5 give 5 to 10 clocks, code 6 gives 11 clocks and code 7 gives 13 clocks.
- R6: After a taken write, `busy` is 1 for exactly `TMRD` cycles (default 4). An extended write sampled on the edge where `busy` has just returned to 0 is taken.
- R7: An extended write is refused under any of these conditions: `busy` is 1, `banksIdle` is 0, or `cke` was not 1 both on the command edge and on the edge before it. On refusal, `rejectErr` pulses for one cycle, and the stored fields and `busy` are unchanged.
- R8: A write that passes the R7 checks but has a nonzero address bit above bit 11, or has `termCode` 01, is a protocol error. `protoErr` pulses for one cycle, nothing is stored, and `busy` stays 0. The R7 refusal takes priority over this check.
- R9: While `rstN` is 0, the stored bits are cleared, except that [3:2] load 2'b11 if `cke` is 1 and 2'b00 otherwise. The value held is the one sampled on the last reset edge. All pulses and `busy` are 0 after reset.
- R10: A plain mode register write (`bankAddr` = 2'b00), or any strobe pattern with `csN` = 1, leaves every output unchanged and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; its release samples `cke` for the termination default |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank address; 2'b01 selects the extended register |
| addr | input | ADDR_W | Address bus; bits above 11 are reserved |
| banksIdle | input | 1 | High when every bank is precharged |
| busy | output | 1 | Settling window active |
| accepted | output | 1 | One-cycle pulse: write stored |
| rejectErr | output | 1 | One-cycle pulse: write refused by the device state |
| protoErr | output | 1 | One-cycle pulse: reserved bit or reserved termination code |
| driveOhms | output | 6 | Output driver impedance in ohms; 0 means automatic calibration |
| termCode | output | 2 | Data termination code |
| odtOn | output | 1 | Data termination active |
| dllEnable | output | 1 | DLL enabled |
| addLatency | output | 1 | Additive latency in clocks |
| wrRecovery | output | 4 | Write recovery time in clocks |
| pullUpOhms | output | 6 | Pull-up resistance in ohms |
| caTermHalf | output | 1 | Command/address termination at half of default |
| vendorIdReq | output | 1 | Vendor ID output requested |

## Verification
The hardest case to bring about is the clock-enable qualification. The command has to arrive on the very first edge after `cke` rises, so that `cke` is high now but was low on the edge before. The stimulus drops `cke`, raises it in the same cycle that carries the command, and expects a refusal. It then issues the command one cycle later and expects it to be taken. The edges of the settling window need the same exact timing: a write is placed on the last busy edge and another on the first free edge. Each of these steps is predicted by a cycle-accurate reference model in the bench.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

  // Strobes from control to datapath, all valid for the current edge
  typedef struct packed {
    logic load;        // capture the address into the stored register
    logic flagReject;  // command refused by device state
    logic flagProto;   // command carried a reserved encoding
  } xmr_strobe_t;

  localparam int FIELD_W   = 12;
  localparam logic [1:0] TERM_RSVD = 2'b01;
  localparam logic [1:0] TERM_ZQ2  = 2'b11;
  localparam logic [1:0] TERM_OFF  = 2'b00;

  function automatic logic [3:0] wrRecFromCode(input logic [2:0] code);
    if (code < 3'd6)       return 4'(code) + 4'd5;
    else if (code == 3'd6) return 4'd11;
    else                   return 4'd13;
  endfunction

  function automatic logic [5:0] driveFromCode(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd0;
      2'b01:   return 6'd30;
      2'b10:   return 6'd40;
      default: return 6'd50;
    endcase
  endfunction

endpackage

// File: rtl/xmr_control.sv
module xmr_control
  import xmr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TMRD   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banksIdle,
  output xmr_strobe_t       strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(TMRD + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMRD);

  logic [CNT_W-1:0] busyCnt;
  logic ckePrev;
  logic cmdHit;
  logic canTake;
  logic rsvdHigh;
  logic protoBad;

  assign cmdHit = !csN && !rasN && !casN && !weN && (bankAddr == 2'b01);

  generate
    if (ADDR_W > FIELD_W) begin : g_rsvd
      assign rsvdHigh = |addr[ADDR_W-1:FIELD_W];
    end else begin : g_noRsvd
      assign rsvdHigh = 1'b0;
    end
  endgenerate

  assign protoBad = rsvdHigh || (addr[3:2] == TERM_RSVD);
  assign canTake  = (busyCnt == '0) && banksIdle && cke && ckePrev;

  always_comb begin
    strobe.load       = cmdHit && canTake && !protoBad;
    strobe.flagReject = cmdHit && !canTake;
    strobe.flagProto  = cmdHit && canTake && protoBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      ckePrev <= 1'b0;
    end else begin
      ckePrev <= cke;
      if (strobe.load)        busyCnt <= CNT_LOAD;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  assert_busy_after_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busy);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_LOAD);
  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.load);
  assert_no_load_open_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    !banksIdle |-> !strobe.load);
  assert_cke_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> cke && ckePrev);
  assert_proto_no_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flagProto && !busy) |=> !busy);

endmodule

// File: rtl/xmr_datapath.sv
module xmr_datapath
  import xmr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic [ADDR_W-1:0] addr,
  input  xmr_strobe_t       strobe,
  output logic              accepted,
  output logic              rejectErr,
  output logic              protoErr,
  output logic [5:0]        driveOhms,
  output logic [1:0]        termCode,
  output logic              odtOn,
  output logic              dllEnable,
  output logic              addLatency,
  output logic [3:0]        wrRecovery,
  output logic [5:0]        pullUpOhms,
  output logic              caTermHalf,
  output logic              vendorIdReq
);
  logic [FIELD_W-1:0] fieldReg;
  logic [FIELD_W-1:0] resetVal;

  always_comb begin
    resetVal      = '0;
    resetVal[3:2] = cke ? TERM_ZQ2 : TERM_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldReg  <= resetVal;
      accepted  <= 1'b0;
      rejectErr <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      if (strobe.load) fieldReg <= addr[FIELD_W-1:0];
      accepted  <= strobe.load;
      rejectErr <= strobe.flagReject;
      protoErr  <= strobe.flagProto;
    end
  end

  always_comb begin
    driveOhms   = driveFromCode(fieldReg[1:0]);
    termCode    = fieldReg[3:2];
    odtOn       = (fieldReg[3:2] != TERM_OFF);
    dllEnable   = !fieldReg[6];
    addLatency  = fieldReg[8];
    wrRecovery  = wrRecFromCode({fieldReg[7], fieldReg[5], fieldReg[4]});
    pullUpOhms  = fieldReg[9] ? 6'd60 : 6'd40;
    vendorIdReq = fieldReg[10];
    caTermHalf  = fieldReg[11];
  end

  assert_hold_unless_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(fieldReg));
  assert_one_result_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accepted, rejectErr, protoErr}));
  assert_term_never_rsvd_R8: assert property (@(posedge clk) disable iff (!rstN)
    termCode != TERM_RSVD);
  assert_accept_follows_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> accepted);

endmodule

// File: rtl/xmr_unit.sv
module xmr_unit
  import xmr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TMRD   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        bankAddr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banksIdle,
  output logic              busy,
  output logic              accepted,
  output logic              rejectErr,
  output logic              protoErr,
  output logic [5:0]        driveOhms,
  output logic [1:0]        termCode,
  output logic              odtOn,
  output logic              dllEnable,
  output logic              addLatency,
  output logic [3:0]        wrRecovery,
  output logic [5:0]        pullUpOhms,
  output logic              caTermHalf,
  output logic              vendorIdReq
);
  xmr_strobe_t strobe;

  xmr_control #(.ADDR_W(ADDR_W), .TMRD(TMRD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .banksIdle(banksIdle),
    .strobe(strobe), .busy(busy)
  );

  xmr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cke(cke), .addr(addr), .strobe(strobe),
    .accepted(accepted), .rejectErr(rejectErr), .protoErr(protoErr),
    .driveOhms(driveOhms), .termCode(termCode), .odtOn(odtOn),
    .dllEnable(dllEnable), .addLatency(addLatency), .wrRecovery(wrRecovery),
    .pullUpOhms(pullUpOhms), .caTermHalf(caTermHalf), .vendorIdReq(vendorIdReq)
  );

endmodule

// File: tb/xmr_unit_test.sv
`timescale 1ns/1ps
module xmr_unit_test;
  localparam int ADDR_W = 13;
  localparam int TMRD   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankAddr = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic banksIdle = 1'b1;
  logic busy, accepted, rejectErr, protoErr, odtOn, dllEnable, addLatency;
  logic caTermHalf, vendorIdReq;
  logic [5:0] driveOhms, pullUpOhms;
  logic [1:0] termCode;
  logic [3:0] wrRecovery;

  xmr_unit #(.ADDR_W(ADDR_W), .TMRD(TMRD)) uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .addr(addr), .banksIdle(banksIdle),
    .busy(busy), .accepted(accepted), .rejectErr(rejectErr), .protoErr(protoErr),
    .driveOhms(driveOhms), .termCode(termCode), .odtOn(odtOn),
    .dllEnable(dllEnable), .addLatency(addLatency), .wrRecovery(wrRecovery),
    .pullUpOhms(pullUpOhms), .caTermHalf(caTermHalf), .vendorIdReq(vendorIdReq)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic acc, rej, pro, bsy;
    logic [5:0] drv;
    logic [1:0] term;
    logic odt, dll, al;
    logic [3:0] twr;
    logic [5:0] pull;
    logic ca, vid;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [11:0] mReg;
  int  mCnt;
  logic mCkePrev;

  function automatic int twrExp(input int c);
    case (c)
      0: return 5;  1: return 6;  2: return 7;  3: return 8;
      4: return 9;  5: return 10; 6: return 11;
      default: return 13;
    endcase
  endfunction

  function automatic exp_t fieldsOf(input logic [11:0] r);
    exp_t e;
    e = '0;
    case (r[1:0])
      2'b00: e.drv = 6'd0;   2'b01: e.drv = 6'd30;
      2'b10: e.drv = 6'd40;  default: e.drv = 6'd50;
    endcase
    e.term = r[3:2];
    e.odt  = (r[3:2] != 2'b00);
    e.dll  = ~r[6];
    e.al   = r[8];
    e.twr  = 4'(twrExp({29'd0, r[7], r[5], r[4]}));
    e.pull = r[9] ? 6'd60 : 6'd40;
    e.vid  = r[10];
    e.ca   = r[11];
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus at the falling edge and pushes the
  // expected post-edge outputs.
  task automatic step(input string tag, input logic c, input logic r, input logic ca,
                      input logic w, input logic [1:0] ba, input logic [ADDR_W-1:0] a,
                      input logic idle, input logic k);
    logic hit, take, bad;
    exp_t e;
    csN = c; rasN = r; casN = ca; weN = w; bankAddr = ba; addr = a;
    banksIdle = idle; cke = k;
    hit  = !c && !r && !ca && !w && (ba == 2'b01);
    take = (mCnt == 0) && idle && k && mCkePrev;
    bad  = a[12] || (a[3:2] == 2'b01);
    if (hit && take && !bad) begin
      mReg = a[11:0];
      mCnt = TMRD;
    end else if (mCnt > 0) begin
      mCnt = mCnt - 1;
    end
    mCkePrev = k;
    e = fieldsOf(mReg);
    e.acc = hit && take && !bad;
    e.rej = hit && !take;
    e.pro = hit && take && bad;
    e.bsy = (mCnt != 0);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idleCycle(input string tag);
    step(tag, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0, 1'b1, 1'b1);
  endtask

  task automatic emrs(input string tag, input logic [ADDR_W-1:0] a);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, a, 1'b1, 1'b1);
  endtask

  task automatic settle(input string tag);
    for (int i = 0; i < TMRD; i++) idleCycle(tag);
  endtask

  task automatic doReset(input logic k);
    @(negedge clk);
    rstN = 1'b0; cke = k;
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mReg = 12'h000;
    mReg[3:2] = k ? 2'b11 : 2'b00;
    mCnt = 0;
    mCkePrev = 1'b0;
  endtask

  // Monitor: pops one expected item per edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, "accepted R1",  int'(accepted),  int'(e.acc));
        chk(t, "rejectErr R7", int'(rejectErr), int'(e.rej));
        chk(t, "protoErr R8",  int'(protoErr),  int'(e.pro));
        chk(t, "busy R6",      int'(busy),      int'(e.bsy));
        chk(t, "driveOhms R2", int'(driveOhms), int'(e.drv));
        chk(t, "termCode R2",  int'(termCode),  int'(e.term));
        chk(t, "odtOn R2",     int'(odtOn),     int'(e.odt));
        chk(t, "dllEnable R3", int'(dllEnable), int'(e.dll));
        chk(t, "addLatency R3", int'(addLatency), int'(e.al));
        chk(t, "pullUpOhms R3", int'(pullUpOhms), int'(e.pull));
        chk(t, "caTermHalf R4", int'(caTermHalf), int'(e.ca));
        chk(t, "vendorIdReq R4", int'(vendorIdReq), int'(e.vid));
        chk(t, "wrRecovery R5", int'(wrRecovery), int'(e.twr));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mReg = '0; mCnt = 0; mCkePrev = 1'b0;
    // R9: default with cke high at reset release
    doReset(1'b1);
    idleCycle("R9");
    idleCycle("R9");

    // R1, R2: basic write, drive codes
    emrs("R1", 13'h001);
    settle("R6");
    for (int d = 0; d < 4; d++) begin
      emrs("R2", 13'(d) | 13'h008);
      settle("R2");
    end
    // R2: termination codes off and ZQ/2
    emrs("R2", 13'h000); settle("R2");
    emrs("R2", 13'h00C); settle("R2");

    // R5: every write recovery code
    for (int c = 0; c < 8; c++) begin
      logic [ADDR_W-1:0] a;
      a = '0;
      a[7] = c[2]; a[5] = c[1]; a[4] = c[0];
      emrs("R5", a);
      settle("R5");
    end

    // R3, R4: single bits and combinations
    emrs("R3", 13'h040); settle("R3");
    emrs("R3", 13'h100); settle("R3");
    emrs("R3", 13'h200); settle("R3");
    emrs("R4", 13'h400); settle("R4");
    emrs("R4", 13'h800); settle("R4");
    emrs("R4", 13'hF4B); settle("R4");

    // R6/R7: write on last busy edge refused, on first free edge taken
    emrs("R6", 13'h00A);
    for (int i = 0; i < TMRD - 1; i++) idleCycle("R6");
    emrs("R7", 13'h003);
    emrs("R6", 13'h002);
    settle("R6");

    // R7: open bank
    step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 13'h001, 1'b0, 1'b1);
    idleCycle("R7");
    // R7: cke low now
    step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 13'h001, 1'b1, 1'b0);
    // R7: cke high now but low on the edge before
    step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 13'h001, 1'b1, 1'b1);
    // now qualified
    emrs("R7", 13'h001);
    settle("R7");

    // R8: reserved address bit, reserved termination code
    emrs("R8", 13'h1001);
    emrs("R8", 13'h004);
    idleCycle("R8");
    // R8 vs R7 priority: reserved code with open bank gives refusal
    step("R8", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 13'h004, 1'b0, 1'b1);
    idleCycle("R8");

    // R10: plain mode register write and deselected strobes
    step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 13'h0FF, 1'b1, 1'b1);
    step("R10", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 13'h0FF, 1'b1, 1'b1);
    step("R10", 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 13'h0FF, 1'b1, 1'b1);
    idleCycle("R10");

    // R9: default with cke low at reset release
    doReset(1'b0);
    step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, '0, 1'b1, 1'b1);
    idleCycle("R9");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule